// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification Register

This block decides which interrupt a UART with permanently enabled FIFOs reports to the host, and produces the interrupt request line. Five sources feed it: receive line errors, receive data at or above the trigger level, receive character timeout, transmit holding register empty, and modem input changes. Each source except receive data is held in a sticky pending flag. The flag is set by an event pulse from the datapath and cleared by the host access that services it. Receive data pending simply follows its level input.

A four-bit enable register masks the sources. The enabled pending sources pass through a fixed priority encoder, and the resulting identification byte is registered together with the interrupt output. The host reads the registered byte. A read of that byte is also a service action for the transmit-empty source, but only when that source is the one being reported. Every pin is plain control or status, with no data stream, so no handshake applies.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x81, the interrupt output is 0 and the enable register reads 0x00.
- R2: Enable bit 0 gates receive data and timeout, bit 1 gates transmit empty, bit 2 gates line errors and bit 3 gates modem changes. Writes to bits 7:4 have no effect, and those bits read 0.
- R3: With no enabled source pending, the identification byte reads 0x81 (low nibble 0001). Bits 6:4 always read 0 and bit 7 always reads 1.
- R4: The low nibble is 0110 for line errors, 0100 for receive data, 1100 for timeout, 0010 for transmit empty and 0000 for modem changes.
- R5: When several enabled sources pend, the highest one is reported. The order from highest is line errors, then receive data (ahead of timeout on the shared level), then timeout, then transmit empty, then modem changes.
- R6: A disabled source keeps its pending state and is reported once it is enabled.
- R7: Line-error pending is set by any bit of `ls_err` and cleared by `lsr_rd`. A new error in the same cycle as the read keeps it set.
- R8: Receive-data pending follows `rx_trig` directly and needs no clearing access.
- R9: Timeout pending is set by `rx_tmo` and cleared by `rbr_rd`. A new timeout in the same cycle keeps it set.
- R10: Modem pending is set by any bit of `ms_chg` and cleared by `msr_rd`. A new change in the same cycle keeps it set.
- R11: Transmit-empty pending is set by `thr_empty` and cleared by `thr_wr`.
- R12: `iir_rd` clears transmit-empty pending only when the byte on `iir_rdata` in that cycle has low nibble 0010. A `thr_empty` pulse in the same cycle keeps it set.
- R13: `iir_rdata` and `irq` are registered. A pending change made at clock edge k shows at edge k+1, and `irq` always equals the inverse of `iir_rdata` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receiver buffer read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| ls_err | input | 4 | Line error event pulses (overrun, parity, framing, break) |
| rx_trig | input | 1 | Receive level at or above trigger (level) |
| rx_tmo | input | 1 | Character timeout event pulse |
| thr_empty | input | 1 | Transmit holding register became empty (pulse) |
| ms_chg | input | 4 | Modem input change event pulses |
| iir_rdata | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that every strobe and event input is a clean synchronous level, sampled only at the rising edge, and that the host reads the identification byte through the registered value on `iir_rdata` during the same cycle as `iir_rd`. They make no assumption about mutual exclusion: a set event and its clearing access may coincide, and several sources may fire at once. The stimulus keeps to single-cycle pulses for events and strobes, holds `rx_trig` as a level, and deliberately lines up set and clear in one cycle to test set-wins behaviour.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W    = 4;
  localparam int NUM_SRC = 5;

  localparam int SRC_LINE    = 0;
  localparam int SRC_RXDATA  = 1;
  localparam int SRC_RXTMO   = 2;
  localparam int SRC_TXEMPTY = 3;
  localparam int SRC_MODEM   = 4;

  typedef enum logic [ID_W-1:0] {
    ID_NONE    = 4'b0001,
    ID_LINE    = 4'b0110,
    ID_RXDATA  = 4'b0100,
    ID_RXTMO   = 4'b1100,
    ID_TXEMPTY = 4'b0010,
    ID_MODEM   = 4'b0000
  } irq_id_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output src_vec_t         src_en
);
  localparam int EN_W  = 4;
  localparam int PAD_W = REG_W - EN_W;

  logic [EN_W-1:0] en_q;
  logic            unused_hi;

  assign unused_hi = ^wdata[REG_W-1:EN_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata[EN_W-1:0];
  end

  assign rdata = {{PAD_W{1'b0}}, en_q};

  always_comb begin
    src_en              = '0;
    src_en[SRC_RXDATA]  = en_q[0];
    src_en[SRC_RXTMO]   = en_q[0];
    src_en[SRC_TXEMPTY] = en_q[1];
    src_en[SRC_LINE]    = en_q[2];
    src_en[SRC_MODEM]   = en_q[3];
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int SET_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             clr_i,
  output logic             pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (|set_i)  pend_o <= 1'b1;
    else if (clr_i)   pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         pend,
  input  src_vec_t         en,
  output logic [REG_W-1:0] id_q,
  output logic             irq_q
);
  localparam int PAD_W = REG_W - ID_W - 1;
  localparam logic [REG_W-1:0] ID_RESET = {1'b1, {PAD_W{1'b0}}, ID_NONE};

  src_vec_t active;
  irq_id_e  code;

  assign active = pend & en;

  always_comb begin
    if      (active[SRC_LINE])    code = ID_LINE;
    else if (active[SRC_RXDATA])  code = ID_RXDATA;
    else if (active[SRC_RXTMO])   code = ID_RXTMO;
    else if (active[SRC_TXEMPTY]) code = ID_TXEMPTY;
    else if (active[SRC_MODEM])   code = ID_MODEM;
    else                          code = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q  <= ID_RESET;
      irq_q <= 1'b0;
    end else begin
      id_q  <= {1'b1, {PAD_W{1'b0}}, code};
      irq_q <= |active;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int LS_W  = 4,
  parameter int MS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [REG_W-1:0] ier_wdata,
  output logic [REG_W-1:0] ier_rdata,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             msr_rd,
  input  logic             thr_wr,
  input  logic [LS_W-1:0]  ls_err,
  input  logic             rx_trig,
  input  logic             rx_tmo,
  input  logic             thr_empty,
  input  logic [MS_W-1:0]  ms_chg,
  output logic [REG_W-1:0] iir_rdata,
  output logic             irq
);
  src_vec_t pend_w;
  src_vec_t en_w;
  logic     tx_clr;

  uart_irq_enable #(.REG_W(REG_W)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ier_wr),
    .wdata  (ier_wdata),
    .rdata  (ier_rdata),
    .src_en (en_w)
  );

  uart_irq_sticky #(.SET_W(LS_W)) u_line (
    .clk(clk), .rst_n(rst_n), .set_i(ls_err), .clr_i(lsr_rd),
    .pend_o(pend_w[SRC_LINE])
  );

  assign pend_w[SRC_RXDATA] = rx_trig;

  uart_irq_sticky #(.SET_W(1)) u_tmo (
    .clk(clk), .rst_n(rst_n), .set_i(rx_tmo), .clr_i(rbr_rd),
    .pend_o(pend_w[SRC_RXTMO])
  );

  // Identification read services transmit-empty only if it is the reported code.
  assign tx_clr = thr_wr | (iir_rd & (iir_rdata[ID_W-1:0] == ID_TXEMPTY));

  uart_irq_sticky #(.SET_W(1)) u_txempty (
    .clk(clk), .rst_n(rst_n), .set_i(thr_empty), .clr_i(tx_clr),
    .pend_o(pend_w[SRC_TXEMPTY])
  );

  uart_irq_sticky #(.SET_W(MS_W)) u_modem (
    .clk(clk), .rst_n(rst_n), .set_i(ms_chg), .clr_i(msr_rd),
    .pend_o(pend_w[SRC_MODEM])
  );

  uart_irq_encode #(.REG_W(REG_W)) u_encode (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_w),
    .en    (en_w),
    .id_q  (iir_rdata),
    .irq_q (irq)
  );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iir_rd,
  input logic       lsr_rd,
  input logic       thr_empty,
  input logic [3:0] ls_err,
  input logic [7:0] iir_rdata,
  input logic [7:0] ier_rdata,
  input logic       irq,
  input logic [4:0] pend,
  input logic [4:0] en
);
  AST_IRQ_TRACKS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iir_rdata[0]); // R13
  AST_UPPER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[7:4] == 4'b1000); // R3
  AST_IER_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ier_rdata[7:4] == 4'b0000); // R2
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[3:0] inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000}); // R4
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && en[0]) |=> iir_rdata[3:0] == 4'b0110); // R5
  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == 5'b0) |=> iir_rdata[3:0] == 4'b0001); // R3
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && ls_err == 4'b0) |=> !pend[0]); // R7
  AST_TX_ID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_rdata[3:0] == 4'b0010 && !thr_empty) |=> !pend[3]); // R12
  AST_TX_KEEP_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    thr_empty |=> pend[3]); // R12
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iir_rd    (iir_rd),
  .lsr_rd    (lsr_rd),
  .thr_empty (thr_empty),
  .ls_err    (ls_err),
  .iir_rdata (iir_rdata),
  .ier_rdata (ier_rdata),
  .irq       (irq),
  .pend      (pend_w),
  .en        (en_w)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_wr = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic [7:0] ier_rdata;
  logic       iir_rd = 1'b0, lsr_rd = 1'b0, rbr_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
  logic [3:0] ls_err = '0;
  logic       rx_trig = 1'b0, rx_tmo = 1'b0, thr_empty = 1'b0;
  logic [3:0] ms_chg = '0;
  logic [7:0] iir_rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference state
  bit       m_ls, m_tmo, m_tx, m_ms;
  bit [3:0] m_ier;
  bit [7:0] m_iir = 8'h81;
  bit       m_irq;

  always #2 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .ier_rdata(ier_rdata), .iir_rd(iir_rd), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd),
    .msr_rd(msr_rd), .thr_wr(thr_wr), .ls_err(ls_err), .rx_trig(rx_trig),
    .rx_tmo(rx_tmo), .thr_empty(thr_empty), .ms_chg(ms_chg),
    .iir_rdata(iir_rdata), .irq(irq)
  );

  function automatic bit [3:0] ref_code(bit ls, bit rd, bit to, bit tx, bit ms);
    if (ls)      return 4'b0110;
    else if (rd) return 4'b0100;
    else if (to) return 4'b1100;
    else if (tx) return 4'b0010;
    else if (ms) return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: model next state from pre-edge inputs, then compare at negedge
  task automatic step(string tag);
    bit [3:0] code;
    bit       tx_clr;
    code   = ref_code(m_ls & m_ier[2], rx_trig & m_ier[0], m_tmo & m_ier[0],
                      m_tx & m_ier[1], m_ms & m_ier[3]);
    tx_clr = thr_wr || (iir_rd && m_iir[3:0] == 4'b0010);
    @(posedge clk);
    m_iir = {4'h8, code};
    m_irq = (code != 4'b0001);
    m_ls  = (ls_err != 0) ? 1'b1 : (lsr_rd ? 1'b0 : m_ls);
    m_tmo = rx_tmo        ? 1'b1 : (rbr_rd ? 1'b0 : m_tmo);
    m_tx  = thr_empty     ? 1'b1 : (tx_clr ? 1'b0 : m_tx);
    m_ms  = (ms_chg != 0) ? 1'b1 : (msr_rd ? 1'b0 : m_ms);
    if (ier_wr) m_ier = ier_wdata[3:0];
    @(negedge clk);
    chk({tag, " id"}, iir_rdata, m_iir);
    chk({tag, " R13 irq"}, {7'b0, irq}, {7'b0, m_irq});
    chk({tag, " ier"}, ier_rdata, {4'h0, m_ier});
    ier_wr = 0; iir_rd = 0; lsr_rd = 0; rbr_rd = 0; msr_rd = 0; thr_wr = 0;
    ls_err = '0; rx_tmo = 0; thr_empty = 0; ms_chg = '0;
  endtask

  task automatic set_ier(logic [7:0] v);
    ier_wr = 1; ier_wdata = v; step("R2 ier write");
  endtask

  task automatic clear_all();
    lsr_rd = 1; rbr_rd = 1; msr_rd = 1; thr_wr = 1; rx_trig = 0;
    step("clear");
    step("clear");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset id", iir_rdata, 8'h81);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    chk("R1 reset ier", ier_rdata, 8'h00);
    rst_n = 1;
    step("R1 idle");

    // R2: upper bits ignored
    set_ier(8'hF5);
    chk("R2 upper ignored", ier_rdata, 8'h05);
    set_ier(8'hFF);
    chk("R2 readback", ier_rdata, 8'h0F);

    // R4/R5: every combination of pending sources
    for (int c = 0; c < 32; c++) begin
      clear_all();
      ls_err = c[0] ? 4'b0100 : 4'b0; rx_trig = c[1]; rx_tmo = c[2];
      thr_empty = c[3]; ms_chg = c[4] ? 4'b0010 : 4'b0;
      step("R5 set");
      step("R5 show");
      chk("R4 R5 code", {4'h0, iir_rdata[3:0]},
          {4'h0, ref_code(c[0], c[1], c[2], c[3], c[4])});
    end
    clear_all();
    chk("R3 idle", iir_rdata, 8'h81);

    // R6: disabled sources hold and appear on enable
    set_ier(8'h00);
    ls_err = 4'b1000; ms_chg = 4'b0001; step("R6 set"); step("R6 masked");
    chk("R6 masked", iir_rdata, 8'h81);
    set_ier(8'h08); step("R6 show");
    chk("R6 modem shown", iir_rdata, 8'h80);
    set_ier(8'h0F); step("R6 show");
    chk("R6 line shown", iir_rdata, 8'h86);
    clear_all();

    // R7: line clear, and set wins over read
    ls_err = 4'b0001; step("R7 set");
    lsr_rd = 1; ls_err = 4'b0010; step("R7 race");
    step("R7 race");
    chk("R7 set wins", iir_rdata, 8'h86);
    lsr_rd = 1; step("R7 clr"); step("R7 clr");
    chk("R7 cleared", iir_rdata, 8'h81);

    // R8: receive data follows level
    rx_trig = 1; step("R8"); step("R8");
    chk("R8 level", iir_rdata, 8'h84);
    rx_trig = 0; step("R8"); step("R8");
    chk("R8 drop", iir_rdata, 8'h81);

    // R9: timeout
    rx_tmo = 1; step("R9"); step("R9");
    chk("R9 shown", iir_rdata, 8'h8C);
    rbr_rd = 1; step("R9"); step("R9");
    chk("R9 cleared", iir_rdata, 8'h81);

    // R10: modem
    ms_chg = 4'b0100; step("R10"); step("R10");
    chk("R10 shown", iir_rdata, 8'h80);
    msr_rd = 1; ms_chg = 4'b0001; step("R10 race"); step("R10");
    chk("R10 set wins", iir_rdata, 8'h80);
    msr_rd = 1; step("R10"); step("R10");
    chk("R10 cleared", iir_rdata, 8'h81);

    // R11: transmit write clears
    thr_empty = 1; step("R11"); step("R11");
    chk("R11 shown", iir_rdata, 8'h82);
    thr_wr = 1; step("R11"); step("R11");
    chk("R11 cleared", iir_rdata, 8'h81);

    // R12: identification read clears only when reported
    thr_empty = 1; step("R12"); step("R12");
    iir_rd = 1; step("R12 read"); step("R12");
    chk("R12 read clears", iir_rdata, 8'h81);
    thr_empty = 1; ls_err = 4'b0001; step("R12"); step("R12");
    iir_rd = 1; step("R12 read hidden");
    lsr_rd = 1; step("R12"); step("R12");
    chk("R12 hidden kept", iir_rdata, 8'h82);
    iir_rd = 1; thr_empty = 1; step("R12 race"); step("R12");
    chk("R12 new kept", iir_rdata, 8'h82);
    clear_all();

    // mixed traffic against the reference model
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom;
      ls_err    = (r[3:0] == 0) ? 4'(r[7:4]) : 4'b0;
      rx_tmo    = (r[10:8] == 0);
      thr_empty = (r[13:11] == 0);
      ms_chg    = (r[16:14] == 0) ? 4'b0001 : 4'b0;
      iir_rd    = r[17];
      lsr_rd    = (r[20:18] == 0);
      rbr_rd    = (r[23:21] == 0);
      msr_rd    = (r[26:24] == 0);
      thr_wr    = (r[29:27] == 0);
      if (r[31:30] == 0) rx_trig = ~rx_trig;
      if (k % 500 == 250) begin ier_wr = 1; ier_wdata = 8'($urandom); end
      step("R5 traffic");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule